// File: doc/BRIEF.md
# Protected-Mode Segment Register Loader

This block performs the load of a data-class segment register in protected mode. It takes a 16-bit selector, the target segment slot and the current privilege level. It uses the selector's table bit to pick either the global or the local descriptor table, and checks the selector's index against that table's limit. It then fetches the 8-byte descriptor as four 16-bit words over a word-wide read port with a request/valid handshake.

When the fourth word arrives, the block decodes the access byte and applies three checks in priority order: descriptor class, privilege, then presence. A load that passes commits the base, limit and access byte into the cache entry of the target slot and marks that entry valid. A load that fails leaves every cache entry untouched and reports a 3-bit cause code. A selector with index 0 in the global table is a null selector. It completes without any memory traffic and invalidates the target entry. Each load ends with a single-cycle completion pulse.

The table base and limit values come in as inputs from elsewhere in the core. Gates, system descriptors, task switches and the delivery of exceptions are handled outside this block.

Top module: `seg_load_unit`

## Requirements
- R1: The selector fields are decoded as follows: bits 1:0 are the requested level RPL, bit 2 selects the table (0 global, 1 local), and bits 15:3 are the index. The descriptor byte address is the selected table base plus index times 8. The four words are read at offsets +0, +2, +4 and +6, in that order.
- R2: If index*8+7 is greater than the selected table limit, the load completes with cause 1 (limit). It issues no memory read, and `done` rises in the cycle after the start edge.
- R3: While `mem_req` is high, `mem_addr` holds steady until a cycle in which `mem_valid` is also high, and that cycle accepts the word. `mem_req` is low whenever the block is not busy.
- R4: The descriptor words are used as follows: word 0 is limit[15:0], word 1 is base[15:0], word 2 carries base[23:16] in bits 7:0 and the access byte in bits 15:8, and word 3 is ignored. A passing load writes these values into the target entry and sets its valid bit.
- R5: If access-byte bit 4 (S, descriptor class) is 0, the load completes with cause 2 (type). This check takes priority over the privilege and presence checks.
- R6: The effective level is the larger of `cpl` and RPL. If it exceeds the DPL in access bits 6:5, the load completes with cause 3 (privilege). This check takes priority over the presence check.
- R7: If access-byte bit 7 (present) is 0, the load completes with cause 4 (not present).
- R8: A load that ends with a nonzero cause leaves every cache entry, including its valid bit, unchanged.
- R9: A selector with index 0 and table bit 0 is treated as null. The load issues no memory read, ends with cause 0 in the cycle after the start edge, and clears only the target entry's valid bit.
- R10: `done` is high for exactly one cycle per accepted load. With no read stalls, `done` follows the start edge by 5 cycles when the descriptor is fetched. `fault` changes only together with `done` and holds its value until the next `done`. `ld_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_start | input | 1 | Start a segment load (sampled when not busy) |
| ld_tgt | input | TW | Target segment slot |
| sel | input | 16 | Selector being loaded |
| cpl | input | 2 | Current privilege level (low bits of the code selector) |
| gdt_base | input | 24 | Global table base byte address |
| gdt_limit | input | 16 | Global table limit in bytes |
| ldt_base | input | 24 | Local table base byte address |
| ldt_limit | input | 16 | Local table limit in bytes |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid; accepts the current request |
| mem_rdata | input | 16 | Read data word |
| busy | output | 1 | A descriptor fetch or check is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | Cause of last load: 0 none, 1 limit, 2 type, 3 privilege, 4 not present |
| cache_vld | output | NSEG | Per-slot valid bits |
| cache_base | output | NSEG*24 | Per-slot base, slot s at bits s*24 upward |
| cache_limit | output | NSEG*16 | Per-slot limit |
| cache_acc | output | NSEG*8 | Per-slot access byte |

## Verification
A bad word counter or a bad latched address shows up on `mem_addr` at the next read. A wrong check outcome shows in `fault` in the same cycle as the `done` pulse. A cache entry that was written or cleared when it should not have been shows on the cache ports from the cycle after that edge. The bench therefore compares the whole cache image and the sequence of read addresses after every load. This lets a fault in one slot be caught before a later load can hide it. The sweep covers every combination of DPL, RPL and current level for each slot and both tables, and the timing of `done` is checked exactly.

// File: rtl/seg_pkg.sv
// Shared types for the segment loader.
// Assumes the descriptor base field is 24 bits wide and the limit and selector fields are 16 bits wide.
package seg_pkg;
    localparam int BASE_W = 24;
    localparam int LIM_W  = 16;
    localparam int SEL_W  = 16;
    localparam int ACC_W  = 8;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_LIMIT  = 3'd1,
        FLT_TYPE   = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_ABSENT = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EVAL = 2'd2
    } state_e;

    typedef struct packed {
        logic [LIM_W-1:0]  limit;
        logic [BASE_W-1:0] base;
        logic [ACC_W-1:0]  access;
    } desc_t;
endpackage

// File: rtl/seg_addr_gen.sv
// Selector decode: picks a table, forms the descriptor address and flags
// null and out-of-limit selectors. Purely combinational.
// Assumes descriptors are 8 bytes and the limit is the offset of the table's last valid byte.
module seg_addr_gen
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [BASE_W-1:0] gdt_base,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [BASE_W-1:0] ldt_base,
    input  logic [LIM_W-1:0]  ldt_limit,
    output logic              is_null,
    output logic              limit_bad,
    output logic [BASE_W-1:0] desc_addr
);
    localparam int IDX_W = SEL_W - 3;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [LIM_W:0]    last_byte;
    logic [LIM_W-1:0]  tbl_limit;
    logic [BASE_W-1:0] tbl_base;

    // Field split, table choice and bounds arithmetic.
    always_comb begin
        idx       = sel[SEL_W-1:3];
        use_local = sel[2];
        tbl_base  = use_local ? ldt_base  : gdt_base;
        tbl_limit = use_local ? ldt_limit : gdt_limit;
        last_byte = {1'b0, idx, 3'b000} + (LIM_W+1)'(7);
        limit_bad = last_byte > {1'b0, tbl_limit};
        is_null   = !use_local && (idx == '0);
        desc_addr = tbl_base + {{(BASE_W-SEL_W){1'b0}}, idx, 3'b000};
    end
endmodule

// File: rtl/seg_desc_check.sv
// Access checks on a fetched descriptor, in priority order:
// descriptor class, then privilege, then presence. Combinational.
// Assumes a data-class target, so a system descriptor (S=0) is a type fault.
module seg_desc_check
    import seg_pkg::*;
(
    input  logic [3:0] acc_hi,   // access byte bits 7:4 = {P, DPL[1:0], S}
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    output fault_e     verdict
);
    logic [1:0] epl;
    logic [1:0] dpl;

    // Effective level is the numerically larger of the current and requested levels.
    always_comb begin
        epl = (cpl > rpl) ? cpl : rpl;
        dpl = acc_hi[2:1];
        if (!acc_hi[0])
            verdict = FLT_TYPE;
        else if (epl > dpl)
            verdict = FLT_PRIV;
        else if (!acc_hi[3])
            verdict = FLT_ABSENT;
        else
            verdict = FLT_NONE;
    end
endmodule

// File: rtl/seg_cache.sv
// Per-slot descriptor cache: one entry per segment slot, written on commit and invalidated on a null load.
// Assumes wr_en and inv_en are never high together.
module seg_cache
    import seg_pkg::*;
#(
    parameter int NSEG = 3,
    localparam int TW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   inv_en,
    input  logic [TW-1:0]          slot,
    input  desc_t                  wdata,
    output logic [NSEG-1:0]        vld,
    output logic [NSEG*BASE_W-1:0] base,
    output logic [NSEG*LIM_W-1:0]  limit,
    output logic [NSEG*ACC_W-1:0]  acc
);
    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        localparam logic [TW-1:0] SLOT_ID = TW'(g);

        // Entry storage: clears on a null load, captures on a commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]                    <= 1'b0;
                base[g*BASE_W +: BASE_W]  <= '0;
                limit[g*LIM_W +: LIM_W]   <= '0;
                acc[g*ACC_W +: ACC_W]     <= '0;
            end else if (inv_en && slot == SLOT_ID) begin
                vld[g] <= 1'b0;
            end else if (wr_en && slot == SLOT_ID) begin
                vld[g]                    <= 1'b1;
                base[g*BASE_W +: BASE_W]  <= wdata.base;
                limit[g*LIM_W +: LIM_W]   <= wdata.limit;
                acc[g*ACC_W +: ACC_W]     <= wdata.access;
            end
        end
    end
endmodule

// File: rtl/seg_load_unit.sv
// Protected-mode segment register load sequencer. It accepts a selector,
// bound-checks it against the selected table, fetches four descriptor words,
// checks them and then commits the descriptor or reports a fault cause.
// Assumes read data is valid in the same cycle as mem_valid, and that the
// table registers stay stable during a load.
module seg_load_unit
    import seg_pkg::*;
#(
    parameter int NSEG = 3,
    localparam int TW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_start,
    input  logic [TW-1:0]          ld_tgt,
    input  logic [SEL_W-1:0]       sel,
    input  logic [1:0]             cpl,
    input  logic [BASE_W-1:0]      gdt_base,
    input  logic [LIM_W-1:0]       gdt_limit,
    input  logic [BASE_W-1:0]      ldt_base,
    input  logic [LIM_W-1:0]       ldt_limit,
    output logic                   mem_req,
    output logic [BASE_W-1:0]      mem_addr,
    input  logic                   mem_valid,
    input  logic [15:0]            mem_rdata,
    output logic                   busy,
    output logic                   done,
    output logic [2:0]             fault,
    output logic [NSEG-1:0]        cache_vld,
    output logic [NSEG*BASE_W-1:0] cache_base,
    output logic [NSEG*LIM_W-1:0]  cache_limit,
    output logic [NSEG*ACC_W-1:0]  cache_acc
);
    state_e            state;
    logic [1:0]        word_q;
    logic [BASE_W-1:0] addr_q;
    logic [TW-1:0]     tgt_q;
    logic [1:0]        cpl_q;
    logic [1:0]        rpl_q;
    logic [15:0]       w_lim;
    logic [15:0]       w_base;
    logic [15:0]       w_hi;
    logic              done_q;
    fault_e            fault_q;

    logic              is_null;
    logic              limit_bad;
    logic [BASE_W-1:0] desc_addr;
    fault_e            verdict;
    logic              accept;
    logic              wr_en;
    logic              inv_en;
    logic [TW-1:0]     slot;
    desc_t             wdata;

    seg_addr_gen u_addr (
        .sel       (sel),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .ldt_limit (ldt_limit),
        .is_null   (is_null),
        .limit_bad (limit_bad),
        .desc_addr (desc_addr)
    );

    seg_desc_check u_check (
        .acc_hi  (w_hi[15:12]),
        .cpl     (cpl_q),
        .rpl     (rpl_q),
        .verdict (verdict)
    );

    // Cache write controls: commit on a clean check, invalidate on a null load.
    always_comb begin
        accept       = (state == ST_IDLE) && ld_start;
        inv_en       = accept && is_null;
        wr_en        = (state == ST_EVAL) && (verdict == FLT_NONE);
        slot         = inv_en ? ld_tgt : tgt_q;
        wdata.limit  = w_lim;
        wdata.base   = {w_hi[7:0], w_base};
        wdata.access = w_hi[15:8];
    end

    seg_cache #(.NSEG(NSEG)) u_cache (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .inv_en (inv_en),
        .slot   (slot),
        .wdata  (wdata),
        .vld    (cache_vld),
        .base   (cache_base),
        .limit  (cache_limit),
        .acc    (cache_acc)
    );

    // Load sequencer: start decode, word fetch, final verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            word_q  <= '0;
            addr_q  <= '0;
            tgt_q   <= '0;
            cpl_q   <= '0;
            rpl_q   <= '0;
            w_lim   <= '0;
            w_base  <= '0;
            w_hi    <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        tgt_q  <= ld_tgt;
                        cpl_q  <= cpl;
                        rpl_q  <= sel[1:0];
                        addr_q <= desc_addr;
                        word_q <= '0;
                        if (is_null) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_NONE;
                        end else if (limit_bad) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_LIMIT;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_valid) begin
                        case (word_q)
                            2'd0:    w_lim  <= mem_rdata;
                            2'd1:    w_base <= mem_rdata;
                            2'd2:    w_hi   <= mem_rdata;
                            default: ;
                        endcase
                        word_q <= word_q + 2'd1;
                        if (word_q == 2'd3)
                            state <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    done_q  <= 1'b1;
                    fault_q <= verdict;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from sequencer state.
    always_comb begin
        mem_req  = (state == ST_READ);
        mem_addr = addr_q + {{(BASE_W-3){1'b0}}, word_q, 1'b0};
        busy     = (state != ST_IDLE);
        done     = done_q;
        fault    = fault_q;
    end
endmodule

// File: rtl/seg_load_unit_chk.sv
// Protocol and state checks for seg_load_unit. Bound into every instance.
// Assumes the synchronous active-low reset is held for at least one edge.
module seg_load_unit_chk #(
    parameter int NSEG = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mem_req,
    input logic [23:0]            mem_addr,
    input logic                   mem_valid,
    input logic                   busy,
    input logic                   done,
    input logic [2:0]             fault,
    input logic [NSEG-1:0]        cache_vld,
    input logic [NSEG*24-1:0]     cache_base,
    input logic [NSEG*16-1:0]     cache_limit,
    input logic [NSEG*8-1:0]      cache_acc
);
    // R3: an unanswered request keeps its address.
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R3: no memory traffic while idle.
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R8: a faulting load leaves the whole cache untouched.
    p_fault_keeps_cache_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> ($stable(cache_vld) && $stable(cache_base)
                                     && $stable(cache_limit) && $stable(cache_acc)));

    // R10: the cause code moves only with a completion pulse.
    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(fault));

    // R10: completion lands with the sequencer back at rest.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: only defined cause codes are reported.
    p_cause_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault <= 3'd4));
endmodule

bind seg_load_unit seg_load_unit_chk #(.NSEG(NSEG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .cache_vld   (cache_vld),
    .cache_base  (cache_base),
    .cache_limit (cache_limit),
    .cache_acc   (cache_acc)
);

// File: tb/tb_seg_load_unit.sv
// Bench: sweeps privilege combinations over all slots and both tables, then
// covers limit edges, cause priority, null selectors, stalls and busy-start.
module tb_seg_load_unit;
    localparam int NSEG = 3;
    localparam int TW   = 2;
    localparam logic [23:0] GB = 24'h000040;
    localparam logic [15:0] GL = 16'h00FF;
    localparam logic [23:0] LB = 24'h000200;
    localparam logic [15:0] LL = 16'h007F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_start = 1'b0;
    logic [TW-1:0] ld_tgt = '0;
    logic [15:0] sel = '0;
    logic [1:0] cpl = '0;
    logic mem_req;
    logic [23:0] mem_addr;
    logic mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic busy, done;
    logic [2:0] fault;
    logic [NSEG-1:0] cache_vld;
    logic [NSEG*24-1:0] cache_base;
    logic [NSEG*16-1:0] cache_limit;
    logic [NSEG*8-1:0] cache_acc;

    always #2 clk = ~clk;

    seg_load_unit #(.NSEG(NSEG)) dut (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_tgt(ld_tgt),
        .sel(sel), .cpl(cpl), .gdt_base(GB), .gdt_limit(GL),
        .ldt_base(LB), .ldt_limit(LL), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .fault(fault), .cache_vld(cache_vld), .cache_base(cache_base),
        .cache_limit(cache_limit), .cache_acc(cache_acc)
    );

    logic [15:0] mem [0:511];
    int n_checks = 0;
    int n_errors = 0;
    int rd_count = 0;
    logic [23:0] rd_addr [0:3];
    bit stall_en = 1'b0;
    bit stall_ph = 1'b0;
    bit finished = 1'b0;

    logic        m_vld [NSEG];
    logic [23:0] m_base [NSEG];
    logic [15:0] m_lim [NSEG];
    logic [7:0]  m_acc [NSEG];

    // Memory responder: answers requests at the falling edge, optionally every other cycle.
    always @(negedge clk) begin
        if (mem_req && (!stall_en || stall_ph)) begin
            mem_valid = 1'b1;
            mem_rdata = mem[mem_addr[9:1]];
            if (rd_count < 4) rd_addr[rd_count] = mem_addr;
            rd_count++;
        end else begin
            mem_valid = 1'b0;
        end
        if (mem_req) stall_ph = ~stall_ph;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [23:0] tb, input int idx, input logic [15:0] lim,
                            input logic [23:0] base, input logic [7:0] acc, input logic [15:0] rsv);
        int w;
        w = (int'(tb) + idx * 8) / 2;
        mem[w]     = lim;
        mem[w + 1] = base[15:0];
        mem[w + 2] = {acc, base[23:16]};
        mem[w + 3] = rsv;
    endtask

    task automatic cmp_cache(input string req);
        for (int s = 0; s < NSEG; s++) begin
            check(cache_vld[s] == m_vld[s], {req, " valid"}, cache_vld[s], m_vld[s]);
            if (m_vld[s]) begin
                check(cache_base[s*24 +: 24] == m_base[s], {req, " base"}, cache_base[s*24 +: 24], m_base[s]);
                check(cache_limit[s*16 +: 16] == m_lim[s], {req, " limit"}, cache_limit[s*16 +: 16], m_lim[s]);
                check(cache_acc[s*8 +: 8] == m_acc[s], {req, " access"}, cache_acc[s*8 +: 8], m_acc[s]);
            end
        end
    endtask

    // Runs one load; returns the fault seen at done and the cycles waited.
    task automatic do_load(input int tgt, input logic [15:0] s, input logic [1:0] c,
                           output logic [2:0] f, output int wait_n);
        rd_count = 0;
        @(negedge clk);
        ld_tgt = TW'(tgt);
        sel = s;
        cpl = c;
        ld_start = 1'b1;
        @(negedge clk);
        ld_start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 100) begin
            @(negedge clk);
            wait_n++;
        end
        f = fault;
        check(done == 1'b1, "R10 done seen", done, 1);
    endtask

    task automatic pulse_gone(input string req);
        @(negedge clk);
        check(done == 1'b0, req, done, 0);
    endtask

    task automatic expect_read(input logic [23:0] tb, input int idx, input string req);
        check(rd_count == 4, {req, " read count"}, rd_count, 4);
        for (int k = 0; k < 4; k++)
            check(rd_addr[k] == tb + 24'(idx * 8 + k * 2), {req, " read order"}, rd_addr[k], tb + 24'(idx * 8 + k * 2));
    endtask

    initial begin
        logic [2:0] f;
        int wn;
        int n;
        n = 0;
        for (int i = 0; i < 512; i++) mem[i] = 16'hDEAD;
        for (int s = 0; s < NSEG; s++) begin
            m_vld[s] = 1'b0; m_base[s] = '0; m_lim[s] = '0; m_acc[s] = '0;
        end
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10 reset outputs", {busy, done, mem_req}, 0);
        check(cache_vld == '0, "R8 reset cache", cache_vld, 0);
        check(fault == 3'd0, "R10 reset cause", fault, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 sweep: every DPL/RPL/CPL for every slot, alternating tables (R1, R4).
        for (int t = 0; t < NSEG; t++)
            for (int d = 0; d < 4; d++)
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 4; c++) begin
                        logic loc;
                        int idx;
                        logic [23:0] tb, bs;
                        logic [15:0] lm;
                        logic [7:0] ac;
                        int epl;
                        logic [2:0] exp_f;
                        loc = c[0];
                        idx = loc ? (d * 4 + r) : (1 + d * 4 + r);
                        tb = loc ? LB : GB;
                        lm = 16'h1000 ^ 16'(n * 37);
                        bs = 24'h0A0000 + 24'(n * 129);
                        ac = {1'b1, 2'(d), 1'b1, 4'b0010};
                        put_desc(tb, idx, lm, bs, ac, ~16'(n));
                        do_load(t, {13'(idx), loc, 2'(r)}, 2'(c), f, wn);
                        epl = (c > r) ? c : r;
                        exp_f = (epl > d) ? 3'd3 : 3'd0;
                        check(f == exp_f, "R6 privilege verdict", f, exp_f);
                        check(wn == 5, "R10 fetch latency", wn, 5);
                        expect_read(tb, idx, "R1");
                        if (exp_f == 3'd0) begin
                            m_vld[t] = 1'b1; m_base[t] = bs; m_lim[t] = lm; m_acc[t] = ac;
                        end
                        cmp_cache("R4/R8 sweep");
                        n++;
                    end
        pulse_gone("R10 done single cycle");

        // R7: absent descriptor with passing privilege.
        put_desc(GB, 3, 16'h1111, 24'h111111, 8'b0_11_1_0010, 16'h0);
        do_load(1, {13'd3, 1'b0, 2'd0}, 2'd0, f, wn);
        check(f == 3'd4, "R7 not present", f, 4);
        cmp_cache("R8 after absent");
        // R6 over R7: absent and privilege failure.
        put_desc(GB, 4, 16'h2222, 24'h222222, 8'b0_00_1_0010, 16'h0);
        do_load(1, {13'd4, 1'b0, 2'd3}, 2'd0, f, wn);
        check(f == 3'd3, "R6 priority over R7", f, 3);
        // R5: system descriptor, also absent and privilege-failing.
        put_desc(GB, 5, 16'h3333, 24'h333333, 8'b0_00_0_0010, 16'h0);
        do_load(2, {13'd5, 1'b0, 2'd0}, 2'd3, f, wn);
        check(f == 3'd2, "R5 type priority", f, 2);
        put_desc(LB, 6, 16'h3434, 24'h343434, 8'b1_11_0_1010, 16'h0);
        do_load(0, {13'd6, 1'b1, 2'd0}, 2'd0, f, wn);
        check(f == 3'd2, "R5 type fault otherwise clean", f, 2);
        cmp_cache("R8 after type faults");

        // R2: limit boundaries on both tables.
        put_desc(GB, 31, 16'h4444, 24'h444444, 8'b1_11_1_0000, 16'h0);
        do_load(0, {13'd31, 1'b0, 2'd0}, 2'd0, f, wn);
        check(f == 3'd0, "R2 last global entry allowed", f, 0);
        m_vld[0] = 1'b1; m_base[0] = 24'h444444; m_lim[0] = 16'h4444; m_acc[0] = 8'b1_11_1_0000;
        do_load(0, {13'd32, 1'b0, 2'd0}, 2'd0, f, wn);
        check(f == 3'd1, "R2 global past limit", f, 1);
        check(rd_count == 0, "R2 no read on limit fault", rd_count, 0);
        check(wn == 0, "R2 limit fault timing", wn, 0);
        do_load(1, {13'd16, 1'b1, 2'd0}, 2'd0, f, wn);
        check(f == 3'd1, "R2 local past limit", f, 1);
        check(rd_count == 0, "R2 no read local", rd_count, 0);
        do_load(1, {13'h1FFF, 1'b1, 2'd3}, 2'd0, f, wn);
        check(f == 3'd1, "R2 top index", f, 1);
        cmp_cache("R8 after limit faults");

        // R9: null selector on each slot, any RPL.
        for (int t = 0; t < NSEG; t++) begin
            do_load(t, {13'd0, 1'b0, 2'(t)}, 2'd3, f, wn);
            check(f == 3'd0, "R9 null cause", f, 0);
            check(rd_count == 0, "R9 null issues no read", rd_count, 0);
            check(wn == 0, "R9 null timing", wn, 0);
            m_vld[t] = 1'b0;
            cmp_cache("R9 null invalidates only target");
        end
        pulse_gone("R10 done single cycle after null");

        // R3: stalled reads still fetch in order with held addresses.
        stall_en = 1'b1;
        put_desc(LB, 9, 16'h5A5A, 24'h5A5A5A, 8'b1_10_1_0110, 16'hFFFF);
        do_load(2, {13'd9, 1'b1, 2'd1}, 2'd2, f, wn);
        check(f == 3'd0, "R3 stalled load commits", f, 0);
        expect_read(LB, 9, "R3 stalled");
        m_vld[2] = 1'b1; m_base[2] = 24'h5A5A5A; m_lim[2] = 16'h5A5A; m_acc[2] = 8'b1_10_1_0110;
        cmp_cache("R4 stalled commit");
        stall_en = 1'b0;

        // R10: a start while busy is ignored (a null for slot 2 would clear it).
        put_desc(GB, 7, 16'h6767, 24'h676767, 8'b1_11_1_0010, 16'h0);
        rd_count = 0;
        @(negedge clk);
        ld_tgt = 2'd1; sel = {13'd7, 1'b0, 2'd0}; cpl = 2'd0; ld_start = 1'b1;
        @(negedge clk);
        ld_tgt = 2'd2; sel = 16'h0000; ld_start = 1'b1;
        @(negedge clk);
        ld_start = 1'b0;
        wn = 0;
        while (!done && wn < 100) begin @(negedge clk); wn++; end
        check(fault == 3'd0, "R10 first load result", fault, 0);
        m_vld[1] = 1'b1; m_base[1] = 24'h676767; m_lim[1] = 16'h6767; m_acc[1] = 8'b1_11_1_0010;
        repeat (3) begin
            @(negedge clk);
            check(done == 1'b0, "R10 ignored start gives no done", done, 0);
        end
        cmp_cache("R10 busy start ignored");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule